// File: doc/BRIEF.md
# ACPI Embedded Controller Host Mailbox

This block is the register mailbox between a host and an embedded controller, on the model of the ACPI embedded controller interface. The host writes a command byte or up to four data bytes into a four-byte host-to-controller buffer. It reads a status byte, and it reads the byte the controller has left for it. The controller sees the whole buffer and the status byte at all times. It takes the buffer by a read or an acknowledge strobe, posts a reply byte, and sets three flag bits of its own firmware.

Hardware keeps a command marker. A command write sets it. A data write to any byte clears it. The controller uses it to tell the start of a command sequence from plain data. Hardware also runs the input-full and output-full handshake bits. The firmware flags are only register values: the block raises no interrupt of any kind. Both sides are synchronous register ports on one clock.

Top module: `ec_host_mailbox`

## Requirements
- R1: After reset (rst_n low, synchronous), the status byte, the whole buffer and the reply byte are all zero. Status bits 7 and 6 always read 0.
- R2: When host_cmd_we is high at an edge, the command byte is stored in buffer byte 0 (ec_buf[7:0]), bytes 1 to 3 are kept, and status bit 3 (command marker) reads 1 after that edge.
- R3: When host_data_we[i] is high, host_data[8i+7:8i] is stored in buffer byte i, and status bit 3 reads 0 after that edge, whichever bytes were written.
- R4: If a command write and a data write fall in the same cycle, the data write wins: status bit 3 ends 0, and if host_data_we[0] is set, byte 0 takes the data byte and not the command.
- R5: Status bit 1 (input full) becomes 1 after any host command or data write. It becomes 0 after ec_buf_rd or ec_ack, unless a host write falls in the same cycle, in which case it stays 1.
- R6: ec_buf_rd and ec_ack leave status bit 3 and the buffer contents unchanged. Bit 3 changes only on a host write.
- R7: Status bit 0 (output full) becomes 1 after ec_out_we, which loads the reply byte. A host read at offsets 0 to 3 returns the reply byte in the same cycle and clears bit 0. A read at offset 4 returns the status byte and leaves bit 0 alone. If ec_out_we and a data-window read fall in the same cycle, the read sees the old byte and bit 0 ends 1.
- R8: ec_flag_we loads ec_flag_data[2] into status bit 5 (event pending), ec_flag_data[1] into bit 4 (burst) and ec_flag_data[0] into bit 2 (user flag). Host writes never change these bits, and setting them changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cmd_we | input | 1 | Host command write (offset 04h) |
| host_cmd | input | 8 | Host command byte |
| host_data_we | input | 4 | Host data byte writes, one per offset 00h to 03h |
| host_data | input | 32 | Host data bytes, byte i in bits 8i+7:8i |
| host_rd_en | input | 1 | Host read strobe |
| host_raddr | input | 3 | Host read offset (0 to 3 data window, 4 status) |
| host_rdata | output | 8 | Host read data, combinational |
| ec_buf | output | 32 | Host-to-controller buffer |
| ec_status | output | 8 | Status byte as the host sees it |
| ec_buf_rd | input | 1 | Controller reads the buffer, clears input full |
| ec_ack | input | 1 | Controller acknowledge, clears input full |
| ec_out_we | input | 1 | Controller writes the reply byte |
| ec_out_data | input | 8 | Reply byte |
| ec_flag_we | input | 1 | Controller writes the firmware flags |
| ec_flag_data | input | 3 | {event pending, burst, user flag} |

## Verification
The bench drives the collisions where one event would overwrite another. A command write and a byte 0 data write in the same cycle test R4. A design that let the command win would leave the command marker set and the command byte in byte 0. A controller clear that meets a new host write tests R5; done wrong, it drops input full and the controller never sees the new bytes. A reply write that meets a host read tests R7; done wrong, it loses the reply. The bench also checks that the acknowledge keeps the command marker and that a status read does not clear output full. A design that tied the command marker, or the output-full bit, to the wrong strobe would fail these checks.

// File: rtl/mbx_pkg.sv
// Shared constants for the host mailbox: geometry and status bit positions.
// Assumes a byte-wide host port and a status byte at a fixed offset.
package mbx_pkg;
    localparam int DATA_W     = 8;
    localparam int NUM_BYTES  = 4;
    localparam int ADDR_W     = 3;
    localparam int STATUS_OFS = 4;

    // Status bit positions (host-visible layout).
    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_USER  = 2;
    localparam int ST_CMD   = 3;
    localparam int ST_BURST = 4;
    localparam int ST_EVT   = 5;

    // Firmware-owned flag set.
    typedef struct packed {
        logic evt;
        logic burst;
        logic user;
    } fw_flags_t;
endpackage

// File: rtl/mbx_in_buffer.sv
// Host-to-controller buffer with the command marker.
// Assumes at most one command write per cycle; data writes win over it.
module mbx_in_buffer #(
    parameter int NUM_BYTES = 4,
    parameter int DATA_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_we,
    input  logic [DATA_W-1:0]           cmd,
    input  logic [NUM_BYTES-1:0]        data_we,
    input  logic [NUM_BYTES*DATA_W-1:0] data,
    output logic [NUM_BYTES*DATA_W-1:0] buf_q,
    output logic                        cmd_flag
);
    localparam int BUF_W = NUM_BYTES * DATA_W;

    logic data_any;
    assign data_any = |data_we;

    generate
        for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
            if (i == 0) begin : g_first
                // Byte 0 takes a data write first, else a command.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        buf_q[DATA_W-1:0] <= '0;
                    else if (data_we[0])
                        buf_q[DATA_W-1:0] <= data[DATA_W-1:0];
                    else if (cmd_we)
                        buf_q[DATA_W-1:0] <= cmd;
                end
            end else begin : g_rest
                // Higher bytes take data writes only.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        buf_q[i*DATA_W +: DATA_W] <= '0;
                    else if (data_we[i])
                        buf_q[i*DATA_W +: DATA_W] <= data[i*DATA_W +: DATA_W];
                end
            end
        end
    endgenerate

    // Command marker: set by a command, cleared by any data write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_flag <= 1'b0;
        else if (data_any)
            cmd_flag <= 1'b0;
        else if (cmd_we)
            cmd_flag <= 1'b1;
    end

    logic [BUF_W-1:0] unused_width_probe;
    assign unused_width_probe = buf_q;
endmodule

// File: rtl/mbx_out_reg.sv
// Controller-to-host reply byte with the output-full bit.
// Assumes the host read strobe is already decoded to the data window.
module mbx_out_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              host_take,
    output logic [DATA_W-1:0] out_q,
    output logic              obf
);
    // Reply byte register, loaded by the controller.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (wr_en)
            out_q <= wr_data;
    end

    // Output full: a controller write wins over a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            obf <= 1'b0;
        else if (wr_en)
            obf <= 1'b1;
        else if (host_take)
            obf <= 1'b0;
    end
endmodule

// File: rtl/mbx_status.sv
// Input-full bit, firmware flags and status byte assembly.
// Assumes the command marker and output-full bit come from their owners.
module mbx_status
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              ec_clear,
    input  logic              flag_we,
    input  fw_flags_t         flag_d,
    input  logic              cmd_flag,
    input  logic              obf,
    output logic [DATA_W-1:0] status
);
    logic      ibf;
    fw_flags_t flags_q;

    // Input full: a host write wins over a controller clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ibf <= 1'b0;
        else if (host_wr)
            ibf <= 1'b1;
        else if (ec_clear)
            ibf <= 1'b0;
    end

    // Firmware flags, written from the controller side only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (flag_we)
            flags_q <= flag_d;
    end

    // Place each bit at its host-visible position.
    always_comb begin
        status           = '0;
        status[ST_OBF]   = obf;
        status[ST_IBF]   = ibf;
        status[ST_USER]  = flags_q.user;
        status[ST_CMD]   = cmd_flag;
        status[ST_BURST] = flags_q.burst;
        status[ST_EVT]   = flags_q.evt;
    end
endmodule

// File: rtl/mbx_host_read.sv
// Host read decode: selects the reply byte or the status byte.
// Assumes combinational read data valid while the read strobe is high.
module mbx_host_read #(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3,
    parameter int NUM_BYTES  = 4,
    parameter int STATUS_OFS = 4
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [DATA_W-1:0] reply,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rdata,
    output logic              take_reply
);
    logic in_window;
    logic at_status;

    assign in_window  = (int'(raddr) < NUM_BYTES);
    assign at_status  = (int'(raddr) == STATUS_OFS);
    assign take_reply = rd_en && in_window;

    // Read mux; offsets outside both regions read zero.
    always_comb begin
        if (in_window)
            rdata = reply;
        else if (at_status)
            rdata = status;
        else
            rdata = '0;
    end
endmodule

// File: rtl/ec_host_mailbox.sv
// Top of the host/controller mailbox. Ties together buffer, reply path,
// status and read decode. Assumes one shared clock for both sides.
module ec_host_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_BYTES = mbx_pkg::NUM_BYTES,
    parameter int DATA_W    = mbx_pkg::DATA_W,
    parameter int ADDR_W    = mbx_pkg::ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_cmd_we,
    input  logic [DATA_W-1:0]           host_cmd,
    input  logic [NUM_BYTES-1:0]        host_data_we,
    input  logic [NUM_BYTES*DATA_W-1:0] host_data,
    input  logic                        host_rd_en,
    input  logic [ADDR_W-1:0]           host_raddr,
    output logic [DATA_W-1:0]           host_rdata,
    output logic [NUM_BYTES*DATA_W-1:0] ec_buf,
    output logic [DATA_W-1:0]           ec_status,
    input  logic                        ec_buf_rd,
    input  logic                        ec_ack,
    input  logic                        ec_out_we,
    input  logic [DATA_W-1:0]           ec_out_data,
    input  logic                        ec_flag_we,
    input  logic [2:0]                  ec_flag_data
);
    logic              cmd_flag;
    logic              obf;
    logic              take_reply;
    logic [DATA_W-1:0] reply_q;
    logic              host_wr;
    fw_flags_t         flag_d;

    assign host_wr = host_cmd_we || (|host_data_we);
    assign flag_d  = fw_flags_t'(ec_flag_data);

    mbx_in_buffer #(.NUM_BYTES(NUM_BYTES), .DATA_W(DATA_W)) u_inbuf (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(host_cmd_we), .cmd(host_cmd),
        .data_we(host_data_we), .data(host_data),
        .buf_q(ec_buf), .cmd_flag(cmd_flag)
    );

    mbx_out_reg #(.DATA_W(DATA_W)) u_outreg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ec_out_we), .wr_data(ec_out_data),
        .host_take(take_reply),
        .out_q(reply_q), .obf(obf)
    );

    mbx_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .ec_clear(ec_buf_rd || ec_ack),
        .flag_we(ec_flag_we), .flag_d(flag_d),
        .cmd_flag(cmd_flag), .obf(obf),
        .status(ec_status)
    );

    mbx_host_read #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .NUM_BYTES(NUM_BYTES), .STATUS_OFS(STATUS_OFS)
    ) u_hread (
        .rd_en(host_rd_en), .raddr(host_raddr),
        .reply(reply_q), .status(ec_status),
        .rdata(host_rdata), .take_reply(take_reply)
    );
endmodule

// File: rtl/mbx_checker.sv
// Port-level properties of the mailbox; attached to the top by bind.
// Assumes default geometry: four data bytes, status at offset 4.
module mbx_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_cmd_we,
    input logic [7:0]  host_cmd,
    input logic [3:0]  host_data_we,
    input logic        host_rd_en,
    input logic [2:0]  host_raddr,
    input logic [7:0]  host_rdata,
    input logic [31:0] ec_buf,
    input logic [7:0]  ec_status,
    input logic        ec_buf_rd,
    input logic        ec_ack,
    input logic        ec_out_we,
    input logic        ec_flag_we
);
    // R1
    hi_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_status[7:6] == 2'b00);

    // R2
    cmd_mark_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd_we && host_data_we == 4'b0) |=> ec_status[3]);

    // R2
    cmd_byte0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd_we && !host_data_we[0]) |=> ec_buf[7:0] == $past(host_cmd));

    // R3
    cmd_mark_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_data_we != 4'b0) |=> !ec_status[3]);

    // R5
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd_we || host_data_we != 4'b0) |=> ec_status[1]);

    // R5
    ibf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ec_buf_rd || ec_ack) && !host_cmd_we && host_data_we == 4'b0)
        |=> !ec_status[1]);

    // R6
    cmd_mark_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cmd_we && host_data_we == 4'b0) |=> $stable(ec_status[3]));

    // R7
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_out_we |=> ec_status[0]);

    // R7
    obf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && host_raddr < 3'd4 && !ec_out_we) |=> !ec_status[0]);

    // R7
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && host_raddr == 3'd4) |-> host_rdata == ec_status);

    // R8
    fw_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ec_flag_we |=> $stable({ec_status[5:4], ec_status[2]}));
endmodule

bind ec_host_mailbox mbx_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_cmd_we(host_cmd_we), .host_cmd(host_cmd),
    .host_data_we(host_data_we),
    .host_rd_en(host_rd_en), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .ec_buf(ec_buf), .ec_status(ec_status),
    .ec_buf_rd(ec_buf_rd), .ec_ack(ec_ack),
    .ec_out_we(ec_out_we), .ec_flag_we(ec_flag_we)
);

// File: tb/ec_host_mailbox_bench.sv
`timescale 1ns/1ps
module ec_host_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_cmd_we;
    logic [7:0]  host_cmd;
    logic [3:0]  host_data_we;
    logic [31:0] host_data;
    logic        host_rd_en;
    logic [2:0]  host_raddr;
    logic [7:0]  host_rdata;
    logic [31:0] ec_buf;
    logic [7:0]  ec_status;
    logic        ec_buf_rd;
    logic        ec_ack;
    logic        ec_out_we;
    logic [7:0]  ec_out_data;
    logic        ec_flag_we;
    logic [2:0]  ec_flag_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ec_host_mailbox u_ec_host_mailbox (.*);

    typedef struct packed {
        logic        cmd_we;
        logic [7:0]  cmd;
        logic [3:0]  dwe;
        logic [31:0] dat;
        logic        brd;
        logic        ack;
        logic        owe;
        logic [7:0]  odat;
        logic        fwe;
        logic [2:0]  fdat;
        logic [31:0] xbuf;
        logic [7:0]  xstat;
    } vec_t;

    localparam int NV = 11;
    // Fields: cmd_we cmd dwe data brd ack owe odat fwe fdat | exp_buf exp_status
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'hA5, 4'b0000, 32'h0,          1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000, 32'h0000_00A5, 8'h0A}, // R2 R5
        '{1'b0, 8'h00, 4'b0000, 32'h0,          1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 3'b000, 32'h0000_00A5, 8'h08}, // R5 R6
        '{1'b0, 8'h00, 4'b0100, 32'h0033_0000,  1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000, 32'h0033_00A5, 8'h02}, // R3
        '{1'b0, 8'h00, 4'b0000, 32'h0,          1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000, 32'h0033_00A5, 8'h00}, // R5 R6
        '{1'b1, 8'h80, 4'b0001, 32'h0000_0011,  1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000, 32'h0033_0011, 8'h02}, // R4
        '{1'b1, 8'h5C, 4'b0000, 32'h0,          1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000, 32'h0033_005C, 8'h0A}, // R5 set wins
        '{1'b0, 8'h00, 4'b0000, 32'h0,          1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 3'b000, 32'h0033_005C, 8'h0B}, // R7
        '{1'b0, 8'h00, 4'b0000, 32'h0,          1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 3'b111, 32'h0033_005C, 8'h3F}, // R8
        '{1'b0, 8'h00, 4'b1111, 32'hDEAD_BEEF,  1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 3'b010, 32'hDEAD_BEEF, 8'h13}, // R3 R8
        '{1'b0, 8'h00, 4'b0000, 32'h0,          1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 3'b101, 32'hDEAD_BEEF, 8'h25}, // R5 R8
        '{1'b1, 8'h42, 4'b0000, 32'h0,          1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 3'b000, 32'hDEAD_BE42, 8'h2F}  // R2 R8 host cannot touch flags
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        host_cmd_we  = 1'b0; host_cmd = '0;
        host_data_we = '0;   host_data = '0;
        host_rd_en   = 1'b0; host_raddr = '0;
        ec_buf_rd    = 1'b0; ec_ack = 1'b0;
        ec_out_we    = 1'b0; ec_out_data = '0;
        ec_flag_we   = 1'b0; ec_flag_data = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_all();
        idle();
        rst_n = 1'b0;
        do_reset();
        // R1 reset state
        check("R1 status after reset", 32'(ec_status), 32'h00);
        check("R1 buffer after reset", ec_buf, 32'h0);
        host_rd_en = 1'b1; host_raddr = 3'd0; #1;
        check("R1 reply after reset", 32'(host_rdata), 32'h00);
        idle();

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            host_cmd_we  = VEC[i].cmd_we; host_cmd  = VEC[i].cmd;
            host_data_we = VEC[i].dwe;    host_data = VEC[i].dat;
            ec_buf_rd    = VEC[i].brd;    ec_ack    = VEC[i].ack;
            ec_out_we    = VEC[i].owe;    ec_out_data = VEC[i].odat;
            ec_flag_we   = VEC[i].fwe;    ec_flag_data = VEC[i].fdat;
            @(negedge clk);
            idle();
            check($sformatf("vector %0d buffer R2 R3 R4 R6", i), ec_buf, VEC[i].xbuf);
            check($sformatf("vector %0d status R2 R3 R4 R5 R6 R7 R8", i),
                  32'(ec_status), 32'(VEC[i].xstat));
        end

        // R7 status read keeps output full
        host_rd_en = 1'b1; host_raddr = 3'd4; #1;
        check("R7 status read data", 32'(host_rdata), 32'h2F);
        @(negedge clk); idle();
        check("R7 status read keeps OBF", 32'(ec_status[0]), 32'h1);

        // R7 data window read returns reply and clears OBF
        host_rd_en = 1'b1; host_raddr = 3'd2; #1;
        check("R7 window read data", 32'(host_rdata), 32'h77);
        @(negedge clk); idle();
        check("R7 window read clears OBF", 32'(ec_status[0]), 32'h0);

        // R7 reply write meets host read
        host_rd_en = 1'b1; host_raddr = 3'd0;
        ec_out_we = 1'b1; ec_out_data = 8'h99; #1;
        check("R7 collide read sees old byte", 32'(host_rdata), 32'h77);
        @(negedge clk); idle();
        check("R7 collide keeps OBF", 32'(ec_status[0]), 32'h1);
        host_rd_en = 1'b1; host_raddr = 3'd3; #1;
        check("R7 new reply byte", 32'(host_rdata), 32'h99);
        @(negedge clk); idle();

        // R4 command and a non-zero data byte together
        host_cmd_we = 1'b1; host_cmd = 8'hC3;
        host_data_we = 4'b1000; host_data = 32'h1200_0000;
        @(negedge clk); idle();
        check("R4 command kept in byte0", ec_buf, 32'h12AD_BEC3);
        check("R4 marker cleared", 32'(ec_status[3]), 32'h0);

        // R1 reset mid-run
        do_reset();
        check("R1 status after second reset", 32'(ec_status), 32'h00);
        check("R1 buffer after second reset", ec_buf, 32'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog R1 actual=hung expected=finished");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule